// File: doc/BRIEF.md
# First-Edge Serial Mode Selector

The block picks one of two serial programming framings once per power-up. It watches two device pins: a frame enable pin and a shift clock pin. After reset is released it waits for the first rising edge on either pin. The pin that rises first decides the framing, and the block keeps that choice until the next power-on reset. Only rising edges count, because both pins are expected to sit low or undriven while the supply comes up.

Each pin passes through its own multi-flop synchronizer. Edges are detected on the synchronized values. The block has two outputs for the downstream protocol engines: a mode bit and a mode-valid flag. While mode-valid is low the engines stay idle. Once a choice is made, further activity on the pins cannot change it.

Top module: `first_edge_mode_sel`

## Requirements
- R1: While `rst_ni` is low, `mode_valid_o` is 0 and `mode_o` is 0.
- R2: When the frame enable pin shows a rising edge before the shift clock pin, `mode_o` becomes 0 (enable-first framing) and `mode_valid_o` becomes 1.
- R3: When the shift clock pin shows a rising edge before the frame enable pin, `mode_o` becomes 1 (clock-first framing) and `mode_valid_o` becomes 1.
- R4: When both synchronized pins rise in the same clock cycle, `mode_o` becomes 0.
- R5: `mode_valid_o` rises on the (SYNC_STAGES+1)-th rising clock edge after the winning pin goes high. It is still 0 after SYNC_STAGES edges. The default SYNC_STAGES is 2.
- R6: Once `mode_valid_o` is 1, it stays 1 and `mode_o` stays constant until reset, whatever either pin does.
- R7: `mode_valid_o` stays 0 for as long as no rising edge has been seen on either pin since reset.
- R8: After each reset, the selection is made anew from the first edge that follows it. The result of earlier power cycles has no effect.
- R9: A pin that pulses high for two clock cycles and then returns low counts as a rising edge. A later edge on the other pin then loses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| frame_en_i | input | 1 | Frame enable pin, asynchronous |
| shift_clk_i | input | 1 | Shift clock pin, asynchronous |
| mode_o | output | 1 | Selected framing: 0 enable-first, 1 clock-first |
| mode_valid_o | output | 1 | High once a framing has been selected |

## Verification
On every cycle, the assertions check the following:
- a locked choice never changes;
- `mode_valid_o` only rises right after a detected edge;
- a lone edge on either pin, or a tie between them, lands on the correct mode in the next cycle.

The following can only be shown by the bench's scenarios, which drive the pins from the outside:
- the synchronizer latency, counted in clock edges from the pin change;
- the sweep over every pair of pin arrival times, with level and pulse stimulus;
- the fresh selection after every reset.

// File: rtl/mode_sel_pkg.sv
package mode_sel_pkg;
  // pin lanes; lane 0 wins ties
  localparam int unsigned NUM_PINS   = 2;
  localparam int unsigned LANE_FRAME = 0;
  localparam int unsigned LANE_SHIFT = 1;

  typedef enum logic {
    MODE_ENABLE_FIRST = 1'b0,
    MODE_CLOCK_FIRST  = 1'b1
  } frame_mode_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_lane
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else if (STAGES == 1) chain_q <= async_i[b];
      else chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/rise_detect.sv
module rise_detect #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/first_edge_arbiter.sv
module first_edge_arbiter
  import mode_sel_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] rise_i,
  output frame_mode_e         mode_o,
  output logic                valid_o
);
  frame_mode_e mode_q;
  logic        valid_q;
  logic        take;

  assign take = !valid_q && (|rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      mode_q  <= MODE_ENABLE_FIRST;
    end else if (take) begin
      valid_q <= 1'b1;
      mode_q  <= rise_i[LANE_FRAME] ? MODE_ENABLE_FIRST : MODE_CLOCK_FIRST;
    end
  end

  assign mode_o  = mode_q;
  assign valid_o = valid_q;

  // R6
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> (valid_q && $stable(mode_q)));
endmodule

// File: rtl/first_edge_mode_sel.sv
module first_edge_mode_sel
  import mode_sel_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_en_i,
  input  logic shift_clk_i,
  output logic mode_o,
  output logic mode_valid_o
);
  logic [NUM_PINS-1:0] pins_async;
  logic [NUM_PINS-1:0] pins_sync;
  logic [NUM_PINS-1:0] pins_rise;
  frame_mode_e         mode_sel;
  logic                sel_valid;

  assign pins_async[LANE_FRAME] = frame_en_i;
  assign pins_async[LANE_SHIFT] = shift_clk_i;

  pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pins_async),
    .sync_o (pins_sync)
  );

  rise_detect #(.WIDTH(NUM_PINS)) edge_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(pins_sync),
    .rise_o (pins_rise)
  );

  first_edge_arbiter arb_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (pins_rise),
    .mode_o (mode_sel),
    .valid_o(sel_valid)
  );

  assign mode_o       = mode_sel;
  assign mode_valid_o = sel_valid;

  // R7
  valid_needs_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_valid_o) |-> $past(|pins_rise));

  // R2
  frame_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_valid_o && pins_rise[LANE_FRAME] && !pins_rise[LANE_SHIFT])
      |=> (mode_valid_o && !mode_o));

  // R3
  shift_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_valid_o && pins_rise[LANE_SHIFT] && !pins_rise[LANE_FRAME])
      |=> (mode_valid_o && mode_o));

  // R4
  tie_break_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_valid_o && (&pins_rise)) |=> (mode_valid_o && !mode_o));
endmodule

// File: tb/first_edge_mode_sel_tb_top.sv
module first_edge_mode_sel_tb_top;
  localparam int unsigned SYNC = 2;
  localparam int NEVER = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic frame_en_i = 1'b0;
  logic shift_clk_i = 1'b0;
  logic mode_o;
  logic mode_valid_o;

  int total = 0;
  int bad = 0;

  always #4 clk_i = ~clk_i;

  first_edge_mode_sel #(.SYNC_STAGES(SYNC)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_en_i  (frame_en_i),
    .shift_clk_i (shift_clk_i),
    .mode_o      (mode_o),
    .mode_valid_o(mode_valid_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic power_cycle();
    @(negedge clk_i);
    rst_ni = 1'b0;
    frame_en_i = 1'b0;
    shift_clk_i = 1'b0;
    @(negedge clk_i);
    chk("R1 valid in reset", mode_valid_o, 1'b0);
    chk("R1 mode in reset", mode_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // t_en/t_sh: cycle at which each pin goes high (NEVER = stays low)
  task automatic race(input int t_en, input int t_sh, input bit pulse);
    logic exp_mode;
    logic exp_valid;
    power_cycle();
    for (int k = 0; k < 14; k++) begin
      frame_en_i  = (t_en != NEVER) && (k >= t_en) && (!pulse || k < t_en + 2);
      shift_clk_i = (t_sh != NEVER) && (k >= t_sh) && (!pulse || k < t_sh + 2);
      @(negedge clk_i);
    end
    exp_valid = (t_en != NEVER) || (t_sh != NEVER);
    exp_mode  = exp_valid && (t_sh < t_en);
    if (!exp_valid) begin
      chk("R7 no edge keeps valid low", mode_valid_o, 1'b0);
    end else begin
      chk(pulse ? "R9 pulse valid" : "R8 fresh valid", mode_valid_o, 1'b1);
      if (t_en == t_sh)      chk("R4 tie mode", mode_o, exp_mode);
      else if (t_en < t_sh)  chk("R2 enable first mode", mode_o, exp_mode);
      else                   chk("R3 clock first mode", mode_o, exp_mode);
      // R6: churn both pins after lock
      for (int k = 0; k < 8; k++) begin
        frame_en_i  = k[0];
        shift_clk_i = k[1];
        @(negedge clk_i);
      end
      frame_en_i = 1'b0;
      shift_clk_i = 1'b0;
      repeat (4) @(negedge clk_i);
      chk("R6 valid held", mode_valid_o, 1'b1);
      chk("R6 mode held", mode_o, exp_mode);
    end
  endtask

  task automatic latency(input bit use_shift);
    power_cycle();
    @(negedge clk_i);
    if (use_shift) shift_clk_i = 1'b1;
    else frame_en_i = 1'b1;
    repeat (SYNC) @(posedge clk_i);
    @(negedge clk_i);
    chk("R5 not yet valid", mode_valid_o, 1'b0);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R5 valid on time", mode_valid_o, 1'b1);
    chk(use_shift ? "R3 latency mode" : "R2 latency mode", mode_o, use_shift);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    latency(1'b0);
    latency(1'b1);
    for (int p = 0; p < 2; p++)
      for (int a = 0; a <= NEVER; a++)
        for (int b = 0; b <= NEVER; b++)
          race(a, b, p[0]);
    // R8: a held pin selection, then reset, then the other pin wins
    race(1, NEVER, 1'b0);
    race(NEVER, 1, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule